// File: doc/BRIEF.md
# Register Hazard Resolver for a Five-Stage Pipeline

This block resolves register read-after-write hazards for an in-order pipeline with five stages: fetch, decode/operand read, ALU, memory and register write. Every register write happens at the end of the last stage, so a later write can never pass an earlier one, and a write can never overtake an earlier read. The only conflict left is a younger instruction that reads a register before an older instruction has written it.

Each cycle the decode stage presents the hazard fields of its instruction: a class code, the destination field, two source fields and an immediate flag. The block keeps its own copy of these fields for the ALU, memory and write stages. It advances that copy on every clock edge. When it stalls, it loads a no-operation into the ALU-stage copy. It returns three forwarding selects, one each for the ALU X input, the ALU Y input and the store-data register. It also returns the stall controls: a pause for fetch, a pause for decode, and a bubble request that writes opcode 0 into the ALU stage.

Two parameters pick the variant. `FWD_EN` turns forwarding on or off. `RF_WT` states whether the register file returns a value written in the same cycle to a read in decode. The datapath holds the decode-stage instruction steady while the pauses are high. These pins are plain control and carry no handshake.

Top module: `hz_unit`

## Requirements
- R1: After reset all three stage copies hold no-operations. In the first cycle after reset, with any decode instruction, all selects are 0 and no stall is raised.
- R2: Class codes are NOP=0, ALU=1, LOAD=2, LADR=3, STORE=4, BRANCH=5, BRL=6. Only ALU, LOAD, LADR and BRL write a register, so only they can be a forwarding source or cause a stall. A STORE, BRANCH or NOP whose destination field matches never has an effect.
- R3: Select codes are 0 = register file, 1 = Z4 (memory-stage result), 2 = Z5 (write-stage value). The X input uses rb of an ALU, LOAD, LADR or STORE in the ALU stage. It selects 1 when the memory stage holds ALU, LADR or BRL with a matching destination, else 2 when the write stage holds any writer with a matching destination, else 0.
- R4: The Y input uses rc only for an ALU-class instruction with the immediate flag clear and follows the rule of R3. An immediate form always gives 0.
- R5: When both the memory and write stages match the same source field, the younger result wins (select 1).
- R6: The store-data select uses the destination field of a STORE in the ALU stage, with the sources and priority of R3.
- R7: With FWD_EN=1, a stall is raised only when the ALU stage holds a LOAD whose destination is read by the decode instruction. A read counts through rb for classes ALU, LOAD, LADR and STORE, through rc for a non-immediate ALU, and through ra for a STORE. A LOAD result is never taken from Z4. The dependent instruction instead reaches the ALU stage one cycle later and selects 2.
- R8: A stall raises pause_fetch, pause_decode and bubble together in the same cycle. On the next edge the ALU stage holds a no-operation, so in that cycle all selects are 0.
- R9: Register number 0 is compared like any other register.
- R10: With FWD_EN=0 all selects stay 0. A stall is raised whenever a writer in the ALU or memory stage has a destination read by the decode instruction.
- R11: With RF_WT=0 a writer in the write stage with a destination read by the decode instruction also raises a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_cls | input | 3 | Class code of the decode-stage instruction |
| dec_ra | input | REG_W | Destination (or store-data) register field in decode |
| dec_rb | input | REG_W | First source / address-base register field in decode |
| dec_rc | input | REG_W | Second source register field in decode |
| dec_imm | input | 1 | Decode instruction uses a constant as second operand |
| fwd_x | output | 2 | Source select for the ALU X input |
| fwd_y | output | 2 | Source select for the ALU Y input |
| fwd_md | output | 2 | Source select for the store-data register |
| pause_fetch | output | 1 | Hold the fetch stage this cycle |
| pause_decode | output | 1 | Hold the decode stage this cycle |
| bubble | output | 1 | Write a no-operation into the ALU stage at the next edge |

## Verification
The bench builds two instances from one instruction program. The first uses FWD_EN=1 and RF_WT=1, where the load-use stall, Z4 priority over Z5 and store-data forwarding can all be observed. The second uses FWD_EN=0 and RF_WT=0, where every dependence within three slots must stall and the write-stage comparison is active. Each instance has its own model of the in-flight destinations, so the two stall at different times on the same program. Dense register use drawn from a shift-register sequence over registers 0 to 3 produces back-to-back and overlapping dependences.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [2:0] {
    IC_NOP    = 3'd0,
    IC_ALU    = 3'd1,
    IC_LOAD   = 3'd2,
    IC_LADR   = 3'd3,
    IC_STORE  = 3'd4,
    IC_BRANCH = 3'd5,
    IC_BRL    = 3'd6
  } iclass_e;

  typedef enum logic [1:0] {
    FS_RF = 2'd0,
    FS_Z4 = 2'd1,
    FS_Z5 = 2'd2
  } fsrc_e;

  // class writes a register in the last stage
  function automatic logic writes_rf(iclass_e c);
    return (c == IC_ALU) || (c == IC_LOAD) || (c == IC_LADR) || (c == IC_BRL);
  endfunction

  // class has its final value at the ALU output (usable from Z4)
  function automatic logic result_in_z4(iclass_e c);
    return (c == IC_ALU) || (c == IC_LADR) || (c == IC_BRL);
  endfunction

  function automatic logic reads_base(iclass_e c);
    return (c == IC_ALU) || (c == IC_LOAD) || (c == IC_LADR) || (c == IC_STORE);
  endfunction

  function automatic logic reads_second(iclass_e c, logic imm);
    return (c == IC_ALU) && !imm;
  endfunction

  function automatic logic reads_data(iclass_e c);
    return c == IC_STORE;
  endfunction

endpackage

// File: rtl/hz_shadow_pipe.sv
module hz_shadow_pipe
  import hz_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int DEPTH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inject_nop,
  input  logic [2:0]                   in_cls,
  input  logic [REG_W-1:0]             in_ra,
  input  logic [REG_W-1:0]             in_rb,
  input  logic [REG_W-1:0]             in_rc,
  input  logic                         in_imm,
  output logic [DEPTH-1:0][2:0]        cls_q,
  output logic [DEPTH-1:0][REG_W-1:0]  ra_q,
  output logic [REG_W-1:0]             head_rb,
  output logic [REG_W-1:0]             head_rc,
  output logic                         head_imm
);

  // head slot (ALU stage): takes decode fields or a no-operation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_q[0] <= IC_NOP;
      ra_q[0]  <= '0;
      head_rb  <= '0;
      head_rc  <= '0;
      head_imm <= 1'b0;
    end else if (inject_nop) begin
      cls_q[0] <= IC_NOP;
      ra_q[0]  <= '0;
      head_rb  <= '0;
      head_rc  <= '0;
      head_imm <= 1'b0;
    end else begin
      cls_q[0] <= in_cls;
      ra_q[0]  <= in_ra;
      head_rb  <= in_rb;
      head_rc  <= in_rc;
      head_imm <= in_imm;
    end
  end

  // later slots only carry class and destination
  for (genvar k = 1; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cls_q[k] <= IC_NOP;
        ra_q[k]  <= '0;
      end else begin
        cls_q[k] <= cls_q[k-1];
        ra_q[k]  <= ra_q[k-1];
      end
    end
  end

endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             need,
  input  logic [REG_W-1:0] src,
  input  logic [2:0]       mem_cls,
  input  logic [REG_W-1:0] mem_ra,
  input  logic [2:0]       wb_cls,
  input  logic [REG_W-1:0] wb_ra,
  output logic [1:0]       sel
);

  logic hit_mem, hit_wb;

  always_comb begin
    hit_mem = result_in_z4(iclass_e'(mem_cls)) && (mem_ra == src);
    hit_wb  = writes_rf(iclass_e'(wb_cls)) && (wb_ra == src);
    sel     = FS_RF;
    if (need) begin
      if (hit_mem)     sel = FS_Z4;   // younger result first
      else if (hit_wb) sel = FS_Z5;
    end
  end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
  import hz_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int NSTG   = 3,
  parameter bit FWD_EN = 1'b1,
  parameter bit RF_WT  = 1'b1
) (
  input  logic [2:0]                  d_cls,
  input  logic [REG_W-1:0]            d_ra,
  input  logic [REG_W-1:0]            d_rb,
  input  logic [REG_W-1:0]            d_rc,
  input  logic                        d_imm,
  input  logic [NSTG-1:0][2:0]        stg_cls,
  input  logic [NSTG-1:0][REG_W-1:0]  stg_ra,
  output logic                        stall
);

  logic [NSTG-1:0] hit;
  logic [NSTG-1:0] late;
  logic use_b, use_c, use_a;

  always_comb begin
    use_b = reads_base(iclass_e'(d_cls));
    use_c = reads_second(iclass_e'(d_cls), d_imm);
    use_a = reads_data(iclass_e'(d_cls));
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    always_comb begin
      hit[k] = writes_rf(iclass_e'(stg_cls[k])) &&
               ((use_b && (d_rb == stg_ra[k])) ||
                (use_c && (d_rc == stg_ra[k])) ||
                (use_a && (d_ra == stg_ra[k])));
    end

    // late: the producer in this slot cannot reach the consumer in time
    if (k == NSTG - 1) begin : g_last
      assign late[k] = !RF_WT;
    end else if (FWD_EN && (k == 0)) begin : g_head_fwd
      assign late[k] = (iclass_e'(stg_cls[k]) == IC_LOAD);
    end else if (FWD_EN) begin : g_mid_fwd
      assign late[k] = 1'b0;
    end else begin : g_nofwd
      assign late[k] = 1'b1;
    end
  end

  assign stall = |(hit & late);

endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter bit FWD_EN = 1'b1,
  parameter bit RF_WT  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       dec_cls,
  input  logic [REG_W-1:0] dec_ra,
  input  logic [REG_W-1:0] dec_rb,
  input  logic [REG_W-1:0] dec_rc,
  input  logic             dec_imm,
  output logic [1:0]       fwd_x,
  output logic [1:0]       fwd_y,
  output logic [1:0]       fwd_md,
  output logic             pause_fetch,
  output logic             pause_decode,
  output logic             bubble
);

  localparam int NSTG = 3;   // ALU, memory, write stages
  localparam int NOPS = 3;   // X, Y, store data

  logic                       stall_c;
  logic [NSTG-1:0][2:0]       stg_cls;
  logic [NSTG-1:0][REG_W-1:0] stg_ra;
  logic [REG_W-1:0]           stg3_rb, stg3_rc;
  logic                       stg3_imm;
  logic [2:0]                 stg3_cls, stg4_cls;

  assign stg3_cls = stg_cls[0];
  assign stg4_cls = stg_cls[1];

  hz_shadow_pipe #(.REG_W(REG_W), .DEPTH(NSTG)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .inject_nop (stall_c),
    .in_cls     (dec_cls),
    .in_ra      (dec_ra),
    .in_rb      (dec_rb),
    .in_rc      (dec_rc),
    .in_imm     (dec_imm),
    .cls_q      (stg_cls),
    .ra_q       (stg_ra),
    .head_rb    (stg3_rb),
    .head_rc    (stg3_rc),
    .head_imm   (stg3_imm)
  );

  hz_stall_detect #(.REG_W(REG_W), .NSTG(NSTG), .FWD_EN(FWD_EN), .RF_WT(RF_WT)) u_stall (
    .d_cls   (dec_cls),
    .d_ra    (dec_ra),
    .d_rb    (dec_rb),
    .d_rc    (dec_rc),
    .d_imm   (dec_imm),
    .stg_cls (stg_cls),
    .stg_ra  (stg_ra),
    .stall   (stall_c)
  );

  assign pause_fetch  = stall_c;
  assign pause_decode = stall_c;
  assign bubble       = stall_c;

  if (FWD_EN) begin : g_fwd
    logic [NOPS-1:0]            need;
    logic [NOPS-1:0][REG_W-1:0] src;
    logic [NOPS-1:0][1:0]       sel;

    always_comb begin
      need[0] = reads_base(iclass_e'(stg3_cls));
      need[1] = reads_second(iclass_e'(stg3_cls), stg3_imm);
      need[2] = reads_data(iclass_e'(stg3_cls));
      src[0]  = stg3_rb;
      src[1]  = stg3_rc;
      src[2]  = stg_ra[0];
    end

    for (genvar op = 0; op < NOPS; op++) begin : g_op
      hz_fwd_pick #(.REG_W(REG_W)) u_pick (
        .need    (need[op]),
        .src     (src[op]),
        .mem_cls (stg_cls[1]),
        .mem_ra  (stg_ra[1]),
        .wb_cls  (stg_cls[2]),
        .wb_ra   (stg_ra[2]),
        .sel     (sel[op])
      );
    end

    assign fwd_x  = sel[0];
    assign fwd_y  = sel[1];
    assign fwd_md = sel[2];
  end else begin : g_nofwd
    assign fwd_x  = FS_RF;
    assign fwd_y  = FS_RF;
    assign fwd_md = FS_RF;
  end

endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk
  import hz_pkg::*;
#(
  parameter bit FWD_EN = 1'b1,
  parameter bit RF_WT  = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] fwd_x,
  input logic [1:0] fwd_y,
  input logic [1:0] fwd_md,
  input logic       bubble,
  input logic [2:0] s3_cls,
  input logic       s3_imm,
  input logic [2:0] s4_cls
);

  p_clean_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (fwd_x == 2'd0 && fwd_y == 2'd0 && fwd_md == 2'd0 && !bubble));

  p_sel_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_x != 2'd3 && fwd_y != 2'd3 && fwd_md != 2'd3);

  p_imm_no_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_cls != IC_ALU || s3_imm) |-> fwd_y == 2'd0);

  p_z4_not_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_x == 2'd1 || fwd_y == 2'd1 || fwd_md == 2'd1) |->
      (s4_cls == IC_ALU || s4_cls == IC_LADR || s4_cls == IC_BRL));

  p_bubble_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (fwd_x == 2'd0 && fwd_y == 2'd0 && fwd_md == 2'd0));

  if (FWD_EN && RF_WT) begin : g_fwd_wt
    p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |-> s3_cls == IC_LOAD);

    p_single_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> !bubble);
  end

endmodule

bind hz_unit hz_unit_chk #(.FWD_EN(FWD_EN), .RF_WT(RF_WT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .fwd_x  (fwd_x),
  .fwd_y  (fwd_y),
  .fwd_md (fwd_md),
  .bubble (bubble),
  .s3_cls (stg3_cls),
  .s3_imm (stg3_imm),
  .s4_cls (stg4_cls)
);

// File: tb/hz_unit_test.sv
`timescale 1ns/1ps
module hz_unit_test;

  typedef struct packed {
    logic [2:0] c;
    logic [4:0] ra;
    logic [4:0] rb;
    logic [4:0] rc;
    logic       imm;
  } ins_t;

  typedef struct {
    logic [1:0] x, y, md;
    bit         sa;
    bit         sb;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] a_cls, b_cls;
  logic [4:0] a_ra, a_rb, a_rc, b_ra, b_rb, b_rc;
  logic       a_imm, b_imm;
  logic [1:0] a_x, a_y, a_md, b_x, b_y, b_md;
  logic       a_pf, a_pd, a_bub, b_pf, b_pd, b_bub;

  hz_unit uut (
    .clk(clk), .rst_n(rst_n), .dec_cls(a_cls), .dec_ra(a_ra), .dec_rb(a_rb),
    .dec_rc(a_rc), .dec_imm(a_imm), .fwd_x(a_x), .fwd_y(a_y), .fwd_md(a_md),
    .pause_fetch(a_pf), .pause_decode(a_pd), .bubble(a_bub));

  hz_unit #(.FWD_EN(1'b0), .RF_WT(1'b0)) uut_stall (
    .clk(clk), .rst_n(rst_n), .dec_cls(b_cls), .dec_ra(b_ra), .dec_rb(b_rb),
    .dec_rc(b_rc), .dec_imm(b_imm), .fwd_x(b_x), .fwd_y(b_y), .fwd_md(b_md),
    .pause_fetch(b_pf), .pause_decode(b_pd), .bubble(b_bub));

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 1'b0;
  ins_t prog[$];
  exp_t q[$];
  ins_t pa[3];
  ins_t pb[3];
  localparam ins_t NOPI = '0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic add(input logic [2:0] c, input int ra, input int rb, input int rc, input bit imm);
    ins_t i;
    i.c = c; i.ra = 5'(ra); i.rb = 5'(rb); i.rc = 5'(rc); i.imm = imm;
    prog.push_back(i);
  endtask

  // reference rules written from the requirements
  function automatic bit is_wr(logic [2:0] c);
    return c == 3'd1 || c == 3'd2 || c == 3'd3 || c == 3'd6;
  endfunction
  function automatic bit early(logic [2:0] c);
    return c == 3'd1 || c == 3'd3 || c == 3'd6;
  endfunction
  function automatic bit rdx(logic [2:0] c);
    return c == 3'd1 || c == 3'd2 || c == 3'd3 || c == 3'd4;
  endfunction
  function automatic bit uses(ins_t d, logic [4:0] r);
    return (rdx(d.c) && d.rb == r) || (d.c == 3'd1 && !d.imm && d.rc == r) ||
           (d.c == 3'd4 && d.ra == r);
  endfunction
  function automatic logic [1:0] pick(ins_t m, ins_t w, bit need, logic [4:0] r);
    if (!need) return 2'd0;
    if (early(m.c) && m.ra == r) return 2'd1;
    if (is_wr(w.c) && w.ra == r) return 2'd2;
    return 2'd0;
  endfunction
  function automatic bit stall_a(ins_t d);
    return pa[0].c == 3'd2 && uses(d, pa[0].ra);
  endfunction
  function automatic bit stall_b(ins_t d);
    bit s = 1'b0;
    for (int k = 0; k < 3; k++) if (is_wr(pb[k].c) && uses(d, pb[k].ra)) s = 1'b1;
    return s;
  endfunction

  task automatic drive(input ins_t a, input ins_t b);
    a_cls = a.c; a_ra = a.ra; a_rb = a.rb; a_rc = a.rc; a_imm = a.imm;
    b_cls = b.c; b_ra = b.ra; b_rb = b.rb; b_rc = b.rc; b_imm = b.imm;
  endtask

  // monitor: compare the outputs of each cycle against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(a_x == e.x, "R3/R5/R7 fwd_x", a_x, e.x);
        check(a_y == e.y, "R4 fwd_y", a_y, e.y);
        check(a_md == e.md, "R6 fwd_md", a_md, e.md);
        check(a_bub == e.sa, "R7 bubble", a_bub, e.sa);
        check(a_pf == e.sa && a_pd == e.sa, "R8 pauses", {a_pf, a_pd}, {e.sa, e.sa});
        check(b_x == 2'd0 && b_y == 2'd0 && b_md == 2'd0, "R10 no-forward selects",
              {b_x, b_y, b_md}, 0);
        check(b_bub == e.sb && b_pf == e.sb && b_pd == e.sb, "R10/R11 stall",
              b_bub, e.sb);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    ins_t da, db;
    bit sa, sb;
    int ia, ib, drain;
    logic [15:0] lf;

    // first entry also serves the reset check
    add(3'd1, 1, 0, 0, 0);             // ALU r1 <- r0, r0
    // R3 R4: X and Y from Z4, then Y from Z5
    add(3'd1, 4, 1, 1, 0);
    add(3'd1, 5, 9, 1, 0);
    // R5: two writers of r6, younger wins
    add(3'd1, 6, 2, 2, 0);
    add(3'd1, 6, 3, 3, 0);
    add(3'd1, 7, 6, 6, 0);
    // R4: immediate form ignores rc match
    add(3'd1, 8, 2, 3, 0);
    add(3'd1, 9, 8, 8, 1);
    // R7: load-use through rb, then resolved from Z5
    add(3'd2, 10, 2, 0, 0);
    add(3'd1, 11, 10, 3, 0);
    // R7 R6: load then store of the loaded register
    add(3'd2, 12, 2, 0, 0);
    add(3'd4, 12, 2, 0, 0);
    // R6: store data and base from an ALU result
    add(3'd1, 13, 2, 3, 0);
    add(3'd4, 13, 13, 0, 0);
    // R2: store and branch never act as producers
    add(3'd4, 14, 2, 0, 0);
    add(3'd5, 14, 2, 3, 0);
    add(3'd1, 15, 14, 14, 0);
    // R9: register 0 as destination and source
    add(3'd1, 0, 2, 3, 0);
    add(3'd1, 16, 0, 0, 0);
    // R2: load-address and branch-and-link as producers
    add(3'd3, 18, 2, 0, 0);
    add(3'd6, 19, 2, 3, 0);
    add(3'd1, 20, 18, 19, 0);
    // R7: load-use through rc and load feeding a load base
    add(3'd2, 21, 2, 0, 0);
    add(3'd1, 22, 3, 21, 0);
    add(3'd2, 23, 22, 0, 0);
    add(3'd2, 24, 23, 0, 0);
    // dense mix over registers 0..3
    lf = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      add(3'(lf[2:0] % 3'd7), int'(lf[4:3]), int'(lf[6:5]), int'(lf[8:7]), lf[9]);
    end

    drive(NOPI, NOPI);
    for (int k = 0; k < 3; k++) begin pa[k] = NOPI; pb[k] = NOPI; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    da = prog[0]; db = prog[0];
    drive(da, db);
    #1;
    // R1: empty pipe after reset, nothing selected and no stall
    check(a_x == 0 && a_y == 0 && a_md == 0 && !a_bub, "R1 reset state",
          {a_x, a_y, a_md, a_bub}, 0);
    check(b_x == 0 && b_y == 0 && b_md == 0 && !b_bub, "R1 reset state",
          {b_x, b_y, b_md, b_bub}, 0);
    sa = stall_a(da); sb = stall_b(db);
    ia = 0; ib = 0; drain = 0;

    while (drain < 4) begin
      @(posedge clk);
      #1;
      // advance the reference pipes exactly as the edge did (R8)
      pa[2] = pa[1]; pa[1] = pa[0]; pa[0] = sa ? NOPI : da;
      pb[2] = pb[1]; pb[1] = pb[0]; pb[0] = sb ? NOPI : db;
      if (!sa && ia < prog.size()) ia++;
      if (!sb && ib < prog.size()) ib++;
      da = (ia < prog.size()) ? prog[ia] : NOPI;
      db = (ib < prog.size()) ? prog[ib] : NOPI;
      drive(da, db);
      begin
        exp_t e;
        e.x  = pick(pa[1], pa[2], rdx(pa[0].c), pa[0].rb);
        e.y  = pick(pa[1], pa[2], pa[0].c == 3'd1 && !pa[0].imm, pa[0].rc);
        e.md = pick(pa[1], pa[2], pa[0].c == 3'd4, pa[0].ra);
        sa   = stall_a(da);
        sb   = stall_b(db);
        e.sa = sa;
        e.sb = sb;
        q.push_back(e);
      end
      if (ia >= prog.size() && ib >= prog.size()) drain++;
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    report();
  end

endmodule